// File: doc/BRIEF.md
# Host Command Parser and Response Framer

This block sits between a byte-wide receive FIFO from a USB device controller and the capture engine of a 32-channel logic analyser. Every host packet has a fixed length of 76 bytes. The block gathers each packet into a shadow buffer and checks the two leading marker bytes. It then decodes the two-byte command at the packet's tail. The start command copies all configuration fields into output registers and raises a one-cycle start strobe. Two further codes are accepted as no-operations. Codes that are not recognised are dropped.

Two commands produce a reply on a 32-bit ready/valid stream. A status request returns a status frame of 256 words (1024 bytes). A data request returns a data frame. The data frame carries a header, the captured words drawn from sample memory through a ready/valid source handshake, and an end marker. Zero words then fill it to the next 128-word (512-byte) boundary. The state machine has six states:

- `ST_RECV`: collects bytes and decodes a finished packet. It moves to `ST_STAT` on a status request and to `ST_DHDR` on a data request.
- `ST_STAT`: emits status words and returns to `ST_RECV` after word 255.
- `ST_DHDR`: emits the data header. It moves to `ST_DDATA`, or straight to `ST_DEND` when the depth is zero.
- `ST_DDATA`: passes source words through. After the last of the latched depth, it moves to `ST_DEND`.
- `ST_DEND`: emits the end marker. It moves to `ST_DPAD`, or to `ST_RECV` when the frame already ends on a boundary.
- `ST_DPAD`: emits zeros up to the boundary, then returns to `ST_RECV`.

Top module: `hcp_top`

## Requirements
- R1: A packet is exactly 76 bytes, sent in a fixed order with every multi-byte field little-endian. The byte offsets are:
  - 0–1: marker
  - 2: rate code
  - 3: trigger flags
  - 4–5: threshold A
  - 6–7: threshold B
  - 8: auxiliary byte A
  - 9: auxiliary byte B
  - 10–13: depth
  - 14–17: pretrigger depth
  - 18–45: trigger block A
  - 46–73: trigger block B
  - 74–75: command

  Byte k of a trigger block is bits [8k+7:8k] of its output.
- R2: A packet whose byte 0 is not 0x7F or whose byte 1 is not 0x01 is consumed and discarded. It causes no strobe, no configuration change and no reply.
- R3: Command bytes 0x1A then 0x2B latch every configuration field and pulse `cfg_start` high for exactly one cycle. This command produces no reply.
- R4: Command bytes 0x3A then 0x4B produce a status frame of exactly 256 words:
  - word 0: 0x2B1A037F
  - word 1: `snap_in`
  - word 2: `cap_state`
  - word 3: `aux_word`
  - word 4: the version parameter
  - words 5–255: zero

  Words 1–3 are sampled when the command is decoded.
- R5: Command bytes 0x5A then 0x6B produce a data frame:
  - 0x2B1A027F
  - then `cfg_depth` words taken in order from the source
  - then 0x4D3C037F
  - then zero words until the frame length is a multiple of 128 words.
- R6: Command bytes 0x9A then 0xAB, and 0xBA then 0xCB, are accepted. They produce no reply and leave the configuration unchanged.
- R7: Any other command code is dropped, with no reply, no strobe and no configuration change.
- R8: While `out_valid` is high and `out_ready` is low, the output word is held. Every frame word is delivered exactly once, in order.
- R9: `in_ready` is low for as long as a reply frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Received command byte |
| in_valid | input | 1 | Received byte present |
| in_ready | output | 1 | Block takes a byte |
| out_data | output | 32 | Response word |
| out_valid | output | 1 | Response word present |
| out_ready | input | 1 | Host side takes the word |
| src_data | input | 32 | Captured word from sample memory |
| src_valid | input | 1 | Captured word present |
| src_ready | output | 1 | Block takes the captured word |
| snap_in | input | 32 | Live channel snapshot |
| cap_state | input | 32 | Capture status word |
| aux_word | input | 32 | Spare status word |
| cfg_start | output | 1 | One-cycle start strobe |
| cfg_rate | output | 8 | Rate code |
| cfg_trig_flags | output | 8 | Trigger enable and combine flags |
| cfg_thr_a | output | 16 | Threshold word, group A |
| cfg_thr_b | output | 16 | Threshold word, group B |
| cfg_aux_a | output | 8 | Auxiliary byte A |
| cfg_aux_b | output | 8 | Auxiliary byte B |
| cfg_depth | output | 32 | Capture depth in words |
| cfg_pretrig | output | 32 | Pretrigger depth |
| cfg_trig_a | output | 224 | Trigger block A |
| cfg_trig_b | output | 224 | Trigger block B |

## Verification
Configuration outputs and the start strobe change on the second rising edge after the last packet byte is taken. The first reply word is valid in the cycle that follows that edge. Because outputs are registered, the bench does not wait for a fixed count. It polls the ports at falling edges and then idles a margin of cycles before reading configuration. It also uses that margin to confirm that no stray word appeared. Reply words are gathered at every handshake under random back-pressure and random source gaps. They are compared in full, by index, against frames built in the bench from the latched values.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
    localparam logic [15:0] MARK_IN    = 16'h017F;
    localparam logic [15:0] CMD_START  = 16'h2B1A;
    localparam logic [15:0] CMD_STATUS = 16'h4B3A;
    localparam logic [15:0] CMD_DATA   = 16'h6B5A;
    localparam logic [15:0] CMD_NOP_A  = 16'hAB9A;
    localparam logic [15:0] CMD_NOP_B  = 16'hCBBA;
    localparam logic [31:0] HDR_STATUS = 32'h2B1A037F;
    localparam logic [31:0] HDR_DATA   = 32'h2B1A027F;
    localparam logic [31:0] END_MARK   = 32'h4D3C037F;

    typedef enum logic [2:0] {
        ST_RECV, ST_STAT, ST_DHDR, ST_DDATA, ST_DEND, ST_DPAD
    } fr_state_t;
endpackage

// File: rtl/hcp_byte_collect.sv
module hcp_byte_collect #(
    parameter int PKT_BYTES = 76
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             in_data,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic                   accept,
    output logic                   pkt_done,
    output logic [PKT_BYTES*8-1:0] pkt
);
    localparam int IW = $clog2(PKT_BYTES);
    localparam logic [IW-1:0] LAST_IDX = IW'(PKT_BYTES - 1);

    logic [IW-1:0] idx;

    assign in_ready = accept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            pkt_done <= 1'b0;
            pkt      <= '0;
        end else begin
            pkt_done <= 1'b0;
            if (in_valid && in_ready) begin
                pkt[idx*8 +: 8] <= in_data;
                if (idx == LAST_IDX) begin
                    idx      <= '0;
                    pkt_done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R1: a full packet needs many bytes, so completion never repeats back to back
    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);
    assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX);
endmodule

// File: rtl/hcp_framer.sv
module hcp_framer
    import hcp_pkg::*;
#(
    parameter int          TRIG_BYTES   = 28,
    parameter int          PKT_BYTES    = 76,
    parameter int          STATUS_BYTES = 1024,
    parameter int          BLOCK_BYTES  = 512,
    parameter logic [31:0] FW_VERSION   = 32'h0001_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pkt_done,
    input  logic [PKT_BYTES*8-1:0]  pkt,
    output logic                    accept,
    output logic [31:0]             out_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    input  logic [31:0]             src_data,
    input  logic                    src_valid,
    output logic                    src_ready,
    input  logic [31:0]             snap_in,
    input  logic [31:0]             cap_state,
    input  logic [31:0]             aux_word,
    output logic                    cfg_start,
    output logic [7:0]              cfg_rate,
    output logic [7:0]              cfg_trig_flags,
    output logic [15:0]             cfg_thr_a,
    output logic [15:0]             cfg_thr_b,
    output logic [7:0]              cfg_aux_a,
    output logic [7:0]              cfg_aux_b,
    output logic [31:0]             cfg_depth,
    output logic [31:0]             cfg_pretrig,
    output logic [TRIG_BYTES*8-1:0] cfg_trig_a,
    output logic [TRIG_BYTES*8-1:0] cfg_trig_b
);
    localparam int STATUS_WORDS = STATUS_BYTES / 4;
    localparam int BLOCK_WORDS  = BLOCK_BYTES / 4;
    localparam int CW = $clog2(STATUS_WORDS);
    localparam int BW = $clog2(BLOCK_WORDS);
    localparam int OFF_RATE  = 2;
    localparam int OFF_FLAGS = 3;
    localparam int OFF_THR_A = 4;
    localparam int OFF_THR_B = 6;
    localparam int OFF_AUX_A = 8;
    localparam int OFF_AUX_B = 9;
    localparam int OFF_DEPTH = 10;
    localparam int OFF_PRE   = 14;
    localparam int OFF_TRG_A = 18;
    localparam int OFF_TRG_B = OFF_TRG_A + TRIG_BYTES;
    localparam int OFF_CMD   = OFF_TRG_B + TRIG_BYTES;
    localparam logic [CW-1:0] STAT_LAST = CW'(STATUS_WORDS - 1);

    fr_state_t      state, state_n;
    logic [CW-1:0]  wcnt;
    logic [31:0]    dcnt;
    logic [31:0]    snap_q, cap_q, aux_q;
    logic [15:0]    cmd;
    logic           mark_ok, decode, fire, blk_last;

    assign cmd      = pkt[OFF_CMD*8 +: 16];
    assign mark_ok  = (pkt[15:0] == MARK_IN);
    assign decode   = (state == ST_RECV) && pkt_done && mark_ok;
    assign fire     = out_valid && out_ready;
    assign blk_last = (wcnt[BW-1:0] == {BW{1'b1}});

    always_comb begin
        state_n = state;
        unique case (state)
            ST_RECV:  if (decode) begin
                          if (cmd == CMD_STATUS)    state_n = ST_STAT;
                          else if (cmd == CMD_DATA) state_n = ST_DHDR;
                      end
            ST_STAT:  if (fire && wcnt == STAT_LAST) state_n = ST_RECV;
            ST_DHDR:  if (fire) state_n = (cfg_depth == 32'd0) ? ST_DEND : ST_DDATA;
            ST_DDATA: if (fire && dcnt == cfg_depth - 32'd1) state_n = ST_DEND;
            ST_DEND:  if (fire) state_n = blk_last ? ST_RECV : ST_DPAD;
            ST_DPAD:  if (fire && blk_last) state_n = ST_RECV;
            default:  state_n = ST_RECV;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RECV;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0; dcnt <= '0; cfg_start <= 1'b0;
            snap_q <= '0; cap_q <= '0; aux_q <= '0;
            cfg_rate <= '0; cfg_trig_flags <= '0; cfg_thr_a <= '0; cfg_thr_b <= '0;
            cfg_aux_a <= '0; cfg_aux_b <= '0; cfg_depth <= '0; cfg_pretrig <= '0;
            cfg_trig_a <= '0; cfg_trig_b <= '0;
        end else begin
            cfg_start <= 1'b0;
            if (decode && cmd == CMD_START) begin
                cfg_start      <= 1'b1;
                cfg_rate       <= pkt[OFF_RATE*8 +: 8];
                cfg_trig_flags <= pkt[OFF_FLAGS*8 +: 8];
                cfg_thr_a      <= pkt[OFF_THR_A*8 +: 16];
                cfg_thr_b      <= pkt[OFF_THR_B*8 +: 16];
                cfg_aux_a      <= pkt[OFF_AUX_A*8 +: 8];
                cfg_aux_b      <= pkt[OFF_AUX_B*8 +: 8];
                cfg_depth      <= pkt[OFF_DEPTH*8 +: 32];
                cfg_pretrig    <= pkt[OFF_PRE*8 +: 32];
                cfg_trig_a     <= pkt[OFF_TRG_A*8 +: TRIG_BYTES*8];
                cfg_trig_b     <= pkt[OFF_TRG_B*8 +: TRIG_BYTES*8];
            end
            if (decode && cmd == CMD_STATUS) begin
                snap_q <= snap_in;
                cap_q  <= cap_state;
                aux_q  <= aux_word;
            end
            if (state == ST_RECV) begin
                wcnt <= '0;
                dcnt <= '0;
            end else if (fire) begin
                wcnt <= wcnt + 1'b1;
                if (state == ST_DDATA) dcnt <= dcnt + 32'd1;
            end
        end
    end

    always_comb begin
        accept    = 1'b0;
        out_valid = 1'b0;
        out_data  = 32'd0;
        src_ready = 1'b0;
        unique case (state)
            ST_RECV:  accept = 1'b1;
            ST_STAT: begin
                out_valid = 1'b1;
                case (wcnt)
                    CW'(0):  out_data = HDR_STATUS;
                    CW'(1):  out_data = snap_q;
                    CW'(2):  out_data = cap_q;
                    CW'(3):  out_data = aux_q;
                    CW'(4):  out_data = FW_VERSION;
                    default: out_data = 32'd0;
                endcase
            end
            ST_DHDR:  begin out_valid = 1'b1; out_data = HDR_DATA; end
            ST_DDATA: begin
                out_valid = src_valid;
                out_data  = src_data;
                src_ready = out_ready;
            end
            ST_DEND:  begin out_valid = 1'b1; out_data = END_MARK; end
            ST_DPAD:  begin out_valid = 1'b1; out_data = 32'd0; end
            default:  accept = 1'b0;
        endcase
    end

    // R8: a stalled word of the block's own making stays put
    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && state != ST_DDATA) |=> (out_valid && $stable(out_data)));
    // R9: no byte intake while a reply word is offered
    assert_no_intake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !accept);
    // R5: every reply ends on a whole block of words
    assert_frame_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECV && $past(state) != ST_RECV) |-> (wcnt[BW-1:0] == '0));
    // R3, R6, R7: configuration moves only together with the start strobe
    assert_cfg_only_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cfg_depth) || !$stable(cfg_rate)) |-> cfg_start);
    // R3: the strobe is a single cycle
    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> !cfg_start);
endmodule

// File: rtl/hcp_top.sv
module hcp_top #(
    parameter int          TRIG_BYTES   = 28,
    parameter int          STATUS_BYTES = 1024,
    parameter int          BLOCK_BYTES  = 512,
    parameter logic [31:0] FW_VERSION   = 32'h0001_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              in_data,
    input  logic                    in_valid,
    output logic                    in_ready,
    output logic [31:0]             out_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    input  logic [31:0]             src_data,
    input  logic                    src_valid,
    output logic                    src_ready,
    input  logic [31:0]             snap_in,
    input  logic [31:0]             cap_state,
    input  logic [31:0]             aux_word,
    output logic                    cfg_start,
    output logic [7:0]              cfg_rate,
    output logic [7:0]              cfg_trig_flags,
    output logic [15:0]             cfg_thr_a,
    output logic [15:0]             cfg_thr_b,
    output logic [7:0]              cfg_aux_a,
    output logic [7:0]              cfg_aux_b,
    output logic [31:0]             cfg_depth,
    output logic [31:0]             cfg_pretrig,
    output logic [TRIG_BYTES*8-1:0] cfg_trig_a,
    output logic [TRIG_BYTES*8-1:0] cfg_trig_b
);
    localparam int PKT_BYTES = 20 + 2 * TRIG_BYTES;

    logic                   accept, pkt_done;
    logic [PKT_BYTES*8-1:0] pkt;

    hcp_byte_collect #(.PKT_BYTES(PKT_BYTES)) u_collect (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .accept(accept), .pkt_done(pkt_done), .pkt(pkt)
    );

    hcp_framer #(
        .TRIG_BYTES(TRIG_BYTES), .PKT_BYTES(PKT_BYTES), .STATUS_BYTES(STATUS_BYTES),
        .BLOCK_BYTES(BLOCK_BYTES), .FW_VERSION(FW_VERSION)
    ) u_framer (
        .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .pkt(pkt), .accept(accept),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
        .snap_in(snap_in), .cap_state(cap_state), .aux_word(aux_word),
        .cfg_start(cfg_start), .cfg_rate(cfg_rate), .cfg_trig_flags(cfg_trig_flags),
        .cfg_thr_a(cfg_thr_a), .cfg_thr_b(cfg_thr_b), .cfg_aux_a(cfg_aux_a),
        .cfg_aux_b(cfg_aux_b), .cfg_depth(cfg_depth), .cfg_pretrig(cfg_pretrig),
        .cfg_trig_a(cfg_trig_a), .cfg_trig_b(cfg_trig_b)
    );
endmodule

// File: tb/hcp_top_test.sv
module hcp_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 76;
    localparam logic [31:0] VER = 32'h00C0_FFEE;

    logic clk = 0, rst_n = 0;
    logic [7:0] in_data = 0; logic in_valid = 0, in_ready;
    logic [31:0] out_data; logic out_valid, out_ready = 0;
    logic [31:0] src_data = 0; logic src_valid = 0, src_ready;
    logic [31:0] snap_in = 0, cap_state = 0, aux_word = 0;
    logic cfg_start; logic [7:0] cfg_rate, cfg_trig_flags, cfg_aux_a, cfg_aux_b;
    logic [15:0] cfg_thr_a, cfg_thr_b; logic [31:0] cfg_depth, cfg_pretrig;
    logic [223:0] cfg_trig_a, cfg_trig_b;

    hcp_top #(.FW_VERSION(VER)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, failures = 0;
    int got_n = 0, starts = 0, busy_intake = 0, cyc = 0;
    int unsigned src_idx = 0;
    logic [31:0] got [0:16383];
    logic [7:0] pb [0:NB-1];
    logic [7:0] e_rate, e_flags, e_aux_a, e_aux_b;
    logic [15:0] e_thr_a, e_thr_b; logic [31:0] e_depth, e_pre;
    logic [223:0] e_trig_a, e_trig_b;

    function automatic logic [31:0] srcw(int unsigned k);
        return (k * 32'h9E3779B9) ^ 32'h5A5A0000 ^ k;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // stimulus of the response side and word capture, away from the rising edge
    always @(negedge clk) begin
        cyc++;
        out_ready = ($urandom % 10) < 7;
        src_valid = ($urandom % 4) != 0;
        src_data  = srcw(src_idx);
        #1;
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (got_n < 16384) got[got_n] = out_data;
                got_n++;
            end
            if (src_valid && src_ready) src_idx++;
            if (cfg_start) starts++;
            if (out_valid && in_ready) busy_intake++;
        end
    end

    initial begin
        wait (cyc > 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_data = b; in_valid = 1;
        #2;
        while (!in_ready) begin @(negedge clk); #2; end
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic build(input logic [7:0] c0, input logic [7:0] c1, input bit good, input logic [31:0] depth);
        for (int i = 0; i < NB; i++) pb[i] = 8'($urandom);
        pb[0] = good ? 8'h7F : 8'h7E;
        pb[1] = 8'h01;
        pb[10] = depth[7:0]; pb[11] = depth[15:8]; pb[12] = depth[23:16]; pb[13] = depth[31:24];
        pb[74] = c0; pb[75] = c1;
    endtask

    task automatic send_pkt();
        for (int i = 0; i < NB; i++) send_byte(pb[i]);
    endtask

    task automatic take_cfg();
        e_rate = pb[2]; e_flags = pb[3]; e_thr_a = {pb[5], pb[4]}; e_thr_b = {pb[7], pb[6]};
        e_aux_a = pb[8]; e_aux_b = pb[9];
        e_depth = {pb[13], pb[12], pb[11], pb[10]}; e_pre = {pb[17], pb[16], pb[15], pb[14]};
        for (int k = 0; k < 28; k++) begin
            e_trig_a[8*k +: 8] = pb[18+k];
            e_trig_b[8*k +: 8] = pb[46+k];
        end
    endtask

    task automatic check_cfg(input string tag);
        chk(cfg_depth == e_depth, {tag, " depth"}, cfg_depth, e_depth);
        chk(cfg_pretrig == e_pre, {tag, " pretrig"}, cfg_pretrig, e_pre);
        chk({cfg_rate, cfg_trig_flags, cfg_aux_a, cfg_aux_b} == {e_rate, e_flags, e_aux_a, e_aux_b},
            {tag, " byte fields"}, {cfg_rate, cfg_trig_flags, cfg_aux_a, cfg_aux_b},
            {e_rate, e_flags, e_aux_a, e_aux_b});
        chk({cfg_thr_b, cfg_thr_a} == {e_thr_b, e_thr_a}, {tag, " thresholds"},
            {cfg_thr_b, cfg_thr_a}, {e_thr_b, e_thr_a});
        chk(cfg_trig_a == e_trig_a && cfg_trig_b == e_trig_b, {tag, " trigger blocks"},
            cfg_trig_a[31:0] ^ cfg_trig_b[31:0], e_trig_a[31:0] ^ e_trig_b[31:0]);
    endtask

    // a packet that must give no reply, no strobe and no configuration change
    task automatic silent_pkt(input logic [7:0] c0, input logic [7:0] c1, input bit good, input string tag);
        int g0, s0;
        g0 = got_n; s0 = starts;
        build(c0, c1, good, $urandom);
        send_pkt();
        repeat (40) @(negedge clk);
        #3;
        chk(got_n == g0, {tag, " no reply"}, got_n - g0, 0);
        chk(starts == s0, {tag, " no strobe"}, starts - s0, 0);
        check_cfg({tag, " cfg unchanged"});
    endtask

    task automatic do_start(input logic [31:0] depth);
        int s0, g0;
        s0 = starts; g0 = got_n;
        build(8'h1A, 8'h2B, 1, depth);
        send_pkt();
        take_cfg();
        repeat (40) @(negedge clk);
        #3;
        chk(starts == s0 + 1, "R3 one start strobe", starts - s0, 1);
        chk(got_n == g0, "R3 no reply to start", got_n - g0, 0);
        check_cfg("R1 R3 latched");
    endtask

    task automatic wait_words(input int base, input int n, input string tag);
        int t;
        t = 0;
        while (got_n < base + n && t < 30000) begin @(negedge clk); t++; end
        repeat (40) @(negedge clk);
        #3;
        chk(got_n - base == n, {tag, " word count"}, got_n - base, n);
    endtask

    task automatic do_status();
        int base, bad;
        logic [31:0] exp, act;
        snap_in = $urandom; cap_state = $urandom % 3; aux_word = $urandom;
        base = got_n;
        build(8'h3A, 8'h4B, 1, $urandom);
        send_pkt();
        wait_words(base, 256, "R4 status");
        bad = 0; exp = 0; act = 0;
        for (int i = 0; i < 256; i++) begin
            logic [31:0] e;
            e = (i == 0) ? 32'h2B1A037F : (i == 1) ? snap_in : (i == 2) ? cap_state :
                (i == 3) ? aux_word : (i == 4) ? VER : 32'd0;
            if (got[base+i] !== e && bad == 0) begin bad = 1; exp = e; act = got[base+i]; end
        end
        chk(bad == 0, "R4 R8 status frame content", act, exp);
    endtask

    task automatic do_data();
        int base, n, bad;
        int unsigned sb;
        logic [31:0] exp, act;
        n = ((int'(e_depth) + 2 + 127) / 128) * 128;
        base = got_n; sb = src_idx;
        build(8'h5A, 8'h6B, 1, $urandom);
        send_pkt();
        wait_words(base, n, "R5 data");
        bad = 0; exp = 0; act = 0;
        for (int i = 0; i < n; i++) begin
            logic [31:0] e;
            if (i == 0) e = 32'h2B1A027F;
            else if (i <= int'(e_depth)) e = srcw(sb + i - 1);
            else if (i == int'(e_depth) + 1) e = 32'h4D3C037F;
            else e = 32'd0;
            if (got[base+i] !== e && bad == 0) begin bad = 1; exp = e; act = got[base+i]; end
        end
        chk(bad == 0, "R5 R8 data frame content", act, exp);
        check_cfg("R5 data request leaves cfg");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        e_rate = 0; e_flags = 0; e_thr_a = 0; e_thr_b = 0; e_aux_a = 0; e_aux_b = 0;
        e_depth = 0; e_pre = 0; e_trig_a = 0; e_trig_b = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #3;
        chk(in_ready == 1, "reset in_ready", 32'(in_ready), 1);
        chk(out_valid == 0, "reset out_valid", 32'(out_valid), 0);
        check_cfg("reset cfg");

        do_start(32'd3);
        do_status();
        do_data();
        do_start(32'd0);   do_data();          // marker straight after header
        do_start(32'd126); do_data();          // exactly one block, no fill
        do_start(32'd127); do_data();          // spills into a second block
        silent_pkt(8'h1A, 8'h2B, 0, "R2 bad marker");
        silent_pkt(8'h9A, 8'hAB, 1, "R6 nop A");
        silent_pkt(8'hBA, 8'hCB, 1, "R6 nop B");
        silent_pkt(8'h3A, 8'h2B, 1, "R7 unknown code");
        silent_pkt(8'h00, 8'h00, 1, "R7 zero code");

        for (int it = 0; it < 10; it++) begin
            case ($urandom % 5)
                0: do_start($urandom % 300);
                1: do_status();
                2: do_data();
                3: silent_pkt(8'($urandom), 8'h5A, 1, "R7 random code");
                default: silent_pkt(8'h5A, 8'h6B, 0, "R2 random bad marker");
            endcase
        end

        chk(busy_intake == 0, "R9 intake closed during reply", busy_intake, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule